// File: doc/BRIEF.md
# Synthesizer Control Write Port

This block is a two-wire serial slave that only accepts writes. It configures a fractional divider synthesizer. A controller addresses the device with a write transfer and then sends a short, strictly ordered run of divider bytes, control bytes, or both. From these bytes the block updates the synthesizer settings it drives: the main divider word, the reference ratio select, the charge-pump controls, the frequency-doubler controls, a test-monitor enable, a tuning-output disable and six switch-output enables.

The bus lines are sampled through a synchronizer clocked by the system clock. START and STOP are recognised from SDA edges while SCL is high. The slave acknowledges by pulling SDA low through a dedicated output. The three divider bytes are collected in a shadow copy, and that copy reaches the divider word only when the transfer ends with STOP, so the divider never sees a half-written word. A control byte takes effect as soon as it has been received. Any byte that breaks the required order is dropped, and it also voids the divider update of its transfer.

Top module: `synth_ctl_i2c`

## Requirements
- R1: After reset, every register output is zero and `sda_low` is released.
- R2: The slave acknowledges only an address byte equal to {5'b11000, addr_sel[1], addr_sel[0], 0}, where the final 0 is the write direction bit. For any other address, or when the direction bit is 1, it gives no acknowledge and every byte up to the next START leaves all outputs unchanged.
- R3: In an addressed write, the slave acknowledges every data byte. It holds `sda_low` high from the SCL fall that ends bit 8 until the SCL fall that ends the ninth clock.
- R4: When the first data byte has bit 7 = 0, the transfer carries divider bytes, in this order. The first byte {0, N[14:8]} sets the upper bits of the word. The second byte {0, N[7:1]} sets the middle bits. The third byte has bits [6:5] as the reference ratio select and bit 0 as N[0]. Bits 4 to 1 of the third byte are ignored.
- R5: `div_word` and `ref_sel` change only in response to a STOP. They never change in the middle of a transfer.
- R6: A transfer that ends after the first or second divider byte updates only the divider bits those bytes carry. The remaining bits keep their values.
- R7: A control byte has bit 7 = 1. The first control byte sets the following fields: bit 6 is `tune_off`, bit 5 is `test_mon`, bit 4 is `cp_off`, bits [3:2] are `cp_code`, bit 1 is `dbl_off` and bit 0 is `dbl_boost`. `cp_code` 0, 1, 2 and 3 select about 50, 100, 150 and 200 µA. The first control byte either follows the third divider byte or opens the transfer, and it takes effect right after it is received.
- R8: The second control byte sets `sw_en` from bits [5:0]. It is accepted only directly after the first control byte.
- R9: A byte that breaks the order changes no output, and the divider bytes of that transfer are not applied at STOP. Three cases break the order: a control byte where a divider byte is expected, a divider byte where a control byte is expected, and any byte after the second control byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| addr_sel | input | 2 | Selects one of four device addresses |
| sda_low | output | 1 | High to pull SDA low (acknowledge) |
| div_word | output | DIV_W | Main divider word |
| ref_sel | output | 2 | Reference ratio select |
| tune_off | output | 1 | Tuning output disable |
| test_mon | output | 1 | Divider monitor enable |
| cp_off | output | 1 | Charge pump disable |
| cp_code | output | 2 | Charge-pump current code |
| dbl_off | output | 1 | Frequency doubler disable |
| dbl_boost | output | 1 | Doubler output current doubled |
| sw_en | output | SW_N | Switch output enables |

## Verification
A bus edge is recognised only after the synchronizer and one registered pulse stage. So `sda_low` moves, and a STOP commits the divider, on the fourth clock after the line change; control fields follow one clock after the acknowledge begins. The bench logs the cycle of every SCL fall or SDA rise it drives and queues the predicted outputs with exactly those offsets. It compares all outputs against the queued prediction at every falling clock edge, so an early or late change fails as clearly as a wrong value.

// File: rtl/synth_ctl_pkg.sv
`timescale 1ns/1ps
package synth_ctl_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      RX_IDLE, RX_ADDR, RX_AACK, RX_DATA, RX_DACK, RX_SKIP
   } rx_state_e;

   typedef enum logic [2:0] {
      SQ_FIRST, SQ_DB2, SQ_DB3, SQ_CB1, SQ_CB2, SQ_DONE
   } seq_state_e;

   // order matches bits [6:0] of the first control byte
   typedef struct packed {
      logic       tune_off;
      logic       test_mon;
      logic       cp_off;
      logic [1:0] cp_code;
      logic       dbl_off;
      logic       dbl_boost;
   } ctl_bits_t;
endpackage

// File: rtl/sci_line_sync.sv
`timescale 1ns/1ps
module sci_line_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_p,
   output logic stop_p,
   output logic sda_lvl
);
   logic scl_s, sda_s, scl_q, sda_q;

   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
      logic scl_r, sda_r;
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_r <= 1'b1;
               sda_r <= 1'b1;
            end else begin
               scl_r <= scl_in;
               sda_r <= sda_in;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_r <= 1'b1;
               sda_r <= 1'b1;
            end else begin
               scl_r <= g_stage[g-1].scl_r;
               sda_r <= g_stage[g-1].sda_r;
            end
         end
      end
   end

   assign scl_s = g_stage[SYNC_STAGES-1].scl_r;
   assign sda_s = g_stage[SYNC_STAGES-1].sda_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
         scl_rise <= 1'b0;
         scl_fall <= 1'b0;
         start_p  <= 1'b0;
         stop_p   <= 1'b0;
         sda_lvl  <= 1'b1;
      end else begin
         scl_q    <= scl_s;
         sda_q    <= sda_s;
         scl_rise <= scl_s & ~scl_q;
         scl_fall <= ~scl_s & scl_q;
         start_p  <= scl_s & scl_q & sda_q & ~sda_s;
         stop_p   <= scl_s & scl_q & ~sda_q & sda_s;
         sda_lvl  <= sda_s;
      end
   end
endmodule

// File: rtl/sci_byte_rx.sv
`timescale 1ns/1ps
module sci_byte_rx
   import synth_ctl_pkg::*;
#(
   parameter logic [4:0] ADDR_HI = 5'b11000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        addr_sel,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_p,
   input  logic              stop_p,
   input  logic              sda_lvl,
   output logic              sda_low,
   output logic              byte_vld,
   output logic [BYTE_W-1:0] byte_dat
);
   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

   rx_state_e         state;
   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] shreg;
   logic              addr_hit;

   assign addr_hit = (shreg == {ADDR_HI, addr_sel, 1'b0});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= RX_IDLE;
         bit_cnt  <= '0;
         shreg    <= '0;
         sda_low  <= 1'b0;
         byte_vld <= 1'b0;
         byte_dat <= '0;
      end else begin
         byte_vld <= 1'b0;
         if (stop_p) begin
            state   <= RX_IDLE;
            sda_low <= 1'b0;
         end else if (start_p) begin
            state   <= RX_ADDR;
            bit_cnt <= '0;
            sda_low <= 1'b0;
         end else begin
            case (state)
               RX_ADDR, RX_DATA: begin
                  if (scl_rise && bit_cnt < LAST_BIT) begin
                     shreg   <= {shreg[BYTE_W-2:0], sda_lvl};
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (scl_fall && bit_cnt == LAST_BIT) begin
                     bit_cnt <= '0;
                     if (state == RX_ADDR) begin
                        if (addr_hit) begin
                           sda_low <= 1'b1;
                           state   <= RX_AACK;
                        end else begin
                           state   <= RX_SKIP;
                        end
                     end else begin
                        sda_low  <= 1'b1;
                        byte_vld <= 1'b1;
                        byte_dat <= shreg;
                        state    <= RX_DACK;
                     end
                  end
               end
               RX_AACK, RX_DACK: begin
                  if (scl_fall) begin
                     sda_low <= 1'b0;
                     state   <= RX_DATA;
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/sci_reg_seq.sv
`timescale 1ns/1ps
module sci_reg_seq
   import synth_ctl_pkg::*;
#(
   parameter int DIV_W = 15,
   parameter int SW_N  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_p,
   input  logic              stop_p,
   input  logic              byte_vld,
   input  logic [BYTE_W-1:0] byte_dat,
   output logic [DIV_W-1:0]  div_word,
   output logic [1:0]        ref_sel,
   output ctl_bits_t         ctl,
   output logic [SW_N-1:0]   sw_en
);
   localparam int SEG_W = BYTE_W - 1;
   localparam int LO_W  = DIV_W - 2 * SEG_W;

   seq_state_e       seq;
   logic             bad, pend, is_cb;
   logic [DIV_W-1:0] sh_div;
   logic [1:0]       sh_ref;

   assign is_cb = byte_dat[BYTE_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq      <= SQ_FIRST;
         bad      <= 1'b0;
         pend     <= 1'b0;
         sh_div   <= '0;
         sh_ref   <= '0;
         div_word <= '0;
         ref_sel  <= '0;
         ctl      <= '0;
         sw_en    <= '0;
      end else if (stop_p) begin
         if (pend && !bad) begin
            div_word <= sh_div;
            ref_sel  <= sh_ref;
         end else begin
            sh_div <= div_word;
            sh_ref <= ref_sel;
         end
         pend <= 1'b0;
         bad  <= 1'b0;
         seq  <= SQ_FIRST;
      end else if (start_p) begin
         seq <= SQ_FIRST;
      end else if (byte_vld) begin
         case (seq)
            SQ_FIRST: begin
               if (is_cb) begin
                  ctl <= ctl_bits_t'(byte_dat[SEG_W-1:0]);
                  seq <= SQ_CB2;
               end else begin
                  sh_div[DIV_W-1 -: SEG_W] <= byte_dat[SEG_W-1:0];
                  pend <= 1'b1;
                  seq  <= SQ_DB2;
               end
            end
            SQ_DB2: begin
               if (!is_cb) begin
                  sh_div[DIV_W-SEG_W-1 -: SEG_W] <= byte_dat[SEG_W-1:0];
                  seq <= SQ_DB3;
               end else begin
                  bad <= 1'b1;
                  seq <= SQ_DONE;
               end
            end
            SQ_DB3: begin
               if (!is_cb) begin
                  sh_div[LO_W-1:0] <= byte_dat[LO_W-1:0];
                  sh_ref <= byte_dat[6:5];
                  seq    <= SQ_CB1;
               end else begin
                  bad <= 1'b1;
                  seq <= SQ_DONE;
               end
            end
            SQ_CB1: begin
               if (is_cb) begin
                  ctl <= ctl_bits_t'(byte_dat[SEG_W-1:0]);
                  seq <= SQ_CB2;
               end else begin
                  bad <= 1'b1;
                  seq <= SQ_DONE;
               end
            end
            SQ_CB2: begin
               if (is_cb) begin
                  sw_en <= byte_dat[SW_N-1:0];
                  seq   <= SQ_DONE;
               end else begin
                  bad <= 1'b1;
                  seq <= SQ_DONE;
               end
            end
            default: bad <= 1'b1;
         endcase
      end
   end
endmodule

// File: rtl/synth_ctl_i2c.sv
`timescale 1ns/1ps
module synth_ctl_i2c
   import synth_ctl_pkg::*;
#(
   parameter int         DIV_W       = 15,
   parameter int         SW_N        = 6,
   parameter int         SYNC_STAGES = 2,
   parameter logic [4:0] ADDR_HI     = 5'b11000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_in,
   input  logic             sda_in,
   input  logic [1:0]       addr_sel,
   output logic             sda_low,
   output logic [DIV_W-1:0] div_word,
   output logic [1:0]       ref_sel,
   output logic             tune_off,
   output logic             test_mon,
   output logic             cp_off,
   output logic [1:0]       cp_code,
   output logic             dbl_off,
   output logic             dbl_boost,
   output logic [SW_N-1:0]  sw_en
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("synth_ctl_i2c: SYNC_STAGES must be 2 or more");
   end
   if (DIV_W < 15 || DIV_W > 19) begin : g_bad_div
      $error("synth_ctl_i2c: DIV_W must lie in 15..19");
   end
   if (SW_N < 1 || SW_N > 7) begin : g_bad_sw
      $error("synth_ctl_i2c: SW_N must lie in 1..7");
   end

   logic              scl_rise, scl_fall, start_p, stop_p, sda_lvl;
   logic              byte_vld;
   logic [BYTE_W-1:0] byte_dat;
   ctl_bits_t         ctl;

   sci_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_p(start_p), .stop_p(stop_p), .sda_lvl(sda_lvl)
   );

   sci_byte_rx #(.ADDR_HI(ADDR_HI)) u_rx (
      .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_p(start_p), .stop_p(stop_p), .sda_lvl(sda_lvl),
      .sda_low(sda_low), .byte_vld(byte_vld), .byte_dat(byte_dat)
   );

   sci_reg_seq #(.DIV_W(DIV_W), .SW_N(SW_N)) u_regs (
      .clk(clk), .rst_n(rst_n), .start_p(start_p), .stop_p(stop_p),
      .byte_vld(byte_vld), .byte_dat(byte_dat),
      .div_word(div_word), .ref_sel(ref_sel), .ctl(ctl), .sw_en(sw_en)
   );

   assign tune_off  = ctl.tune_off;
   assign test_mon  = ctl.test_mon;
   assign cp_off    = ctl.cp_off;
   assign cp_code   = ctl.cp_code;
   assign dbl_off   = ctl.dbl_off;
   assign dbl_boost = ctl.dbl_boost;
endmodule

// File: rtl/synth_ctl_i2c_chk.sv
`timescale 1ns/1ps
module synth_ctl_i2c_chk #(
   parameter int DIV_W = 15,
   parameter int SW_N  = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             scl_in,
   input logic             sda_low,
   input logic             stop_p,
   input logic             byte_vld,
   input logic [DIV_W-1:0] div_word,
   input logic [1:0]       ref_sel,
   input logic [6:0]       ctl_vec,
   input logic [SW_N-1:0]  sw_en
);
   // R3: the acknowledge is asserted only while SCL is low
   p_ack_in_low_scl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_low) |-> !scl_in);

   // R5: divider word and reference select move only after a STOP pulse
   p_div_at_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !stop_p |=> $stable({div_word, ref_sel}));

   // R7: control fields move only after a received data byte
   p_ctl_on_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_vld |=> $stable(ctl_vec));

   // R8: switch enables move only after a received data byte
   p_sw_on_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_vld |=> $stable(sw_en));

   // R2: a STOP always releases the data line
   p_stop_releases_r2: assert property (@(posedge clk) disable iff (!rst_n)
      stop_p |=> !sda_low);
endmodule

bind synth_ctl_i2c synth_ctl_i2c_chk #(.DIV_W(DIV_W), .SW_N(SW_N)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_low(sda_low),
   .stop_p(stop_p), .byte_vld(byte_vld), .div_word(div_word),
   .ref_sel(ref_sel),
   .ctl_vec({tune_off, test_mon, cp_off, cp_code, dbl_off, dbl_boost}),
   .sw_en(sw_en)
);

// File: tb/synth_ctl_i2c_tb.sv
`timescale 1ns/1ps
module synth_ctl_i2c_tb_top;
   localparam int Q  = 8;
   localparam int WD = 150000;

   typedef struct {
      int         due;
      logic [14:0] div;
      logic [1:0]  rsel;
      logic [6:0]  ctl;
      logic [5:0]  sw;
      logic        sdal;
   } snap_t;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        m_scl = 1'b1;
   logic        m_sda = 1'b1;
   logic [1:0]  a_sel = 2'b10;
   logic        sda_low;
   logic [14:0] div_word;
   logic [1:0]  ref_sel, cp_code;
   logic        tune_off, test_mon, cp_off, dbl_off, dbl_boost;
   logic [5:0]  sw_en;
   wire         sda_bus = m_sda & ~sda_low;

   synth_ctl_i2c dut_i (
      .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
      .addr_sel(a_sel), .sda_low(sda_low), .div_word(div_word),
      .ref_sel(ref_sel), .tune_off(tune_off), .test_mon(test_mon),
      .cp_off(cp_off), .cp_code(cp_code), .dbl_off(dbl_off),
      .dbl_boost(dbl_boost), .sw_en(sw_en)
   );

   int    nchk = 0, nerr = 0, cyc = 0;
   bit    done = 0;
   string cur_req = "R1";
   snap_t q[$];
   snap_t cur, plan;

   // protocol model state
   int          m_pos;
   bit          m_bad, m_pend, m_addr;
   logic [14:0] sh_div;
   logic [1:0]  sh_ref;

   function automatic logic [6:0] ctl_now();
      return {tune_off, test_mon, cp_off, cp_code, dbl_off, dbl_boost};
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // every-clock comparison against the queued prediction
   always @(negedge clk) begin
      cyc++;
      if (rst_n && !done) begin
         while (q.size() > 0 && q[0].due <= cyc) cur = q.pop_front();
         chk(cur_req, "R3 sda_low", int'(sda_low), int'(cur.sdal));
         chk(cur_req, "R5 div_word", int'(div_word), int'(cur.div));
         chk(cur_req, "R5 ref_sel", int'(ref_sel), int'(cur.rsel));
         chk(cur_req, "R7 control", int'(ctl_now()), int'(cur.ctl));
         chk(cur_req, "R8 sw_en", int'(sw_en), int'(cur.sw));
      end
   end

   task automatic wt(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic push_at(input int due);
      plan.due = due;
      q.push_back(plan);
   endtask

   task automatic model_byte(input logic [7:0] b);
      int k;
      bit cls = b[7];
      bit legal = (m_pos == 0) || ((m_pos == 1 || m_pos == 2) && !cls) ||
                  ((m_pos == 3 || m_pos == 4) && cls);
      if (!legal) begin
         m_bad = 1;
         m_pos = 5;
         return;
      end
      k = (m_pos == 0) ? (cls ? 3 : 0) : m_pos;
      case (k)
         0: begin sh_div[14:8] = b[6:0]; m_pend = 1; end
         1: sh_div[7:1] = b[6:0];
         2: begin sh_div[0] = b[0]; sh_ref = b[6:5]; end
         3: plan.ctl = b[6:0];
         default: plan.sw = b[5:0];
      endcase
      m_pos = k + 1;
   endtask

   task automatic bus_start();
      m_sda = 1'b0; wt(Q);
      m_scl = 1'b0; wt(Q);
      m_pos = 0;
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wt(Q);
      m_scl = 1'b1; wt(Q);
      m_sda = 1'b1;
      if (m_pend && !m_bad) begin
         plan.div  = sh_div;
         plan.rsel = sh_ref;
      end
      push_at(cyc + 5);
      sh_div = plan.div; sh_ref = plan.rsel;
      m_pend = 0; m_bad = 0; m_addr = 0;
      wt(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, input bit is_addr);
      bit acked;
      int t8;
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; wt(Q);
         m_scl = 1'b1; wt(Q);
         m_scl = 1'b0;
         if (i == 0) begin
            t8 = cyc;
            if (is_addr) begin
               m_addr = (b[7:1] == {5'b11000, a_sel}) && !b[0];
               acked  = m_addr;
            end else begin
               acked = m_addr;
            end
            if (acked) begin
               plan.sdal = 1'b1;
               push_at(t8 + 5);
               if (!is_addr) begin
                  model_byte(b);
                  push_at(t8 + 6);
               end
            end
         end
         wt(Q);
      end
      m_sda = 1'b1; wt(Q);
      m_scl = 1'b1; wt(Q);
      m_scl = 1'b0;
      if (acked) begin
         plan.sdal = 1'b0;
         push_at(cyc + 5);
      end
      wt(Q);
   endtask

   task automatic settle();
      while (q.size() > 0) @(negedge clk);
      repeat (3) @(negedge clk);
      #1;
   endtask

   task automatic final_chk(input string req);
      settle();
      chk(req, "final div_word", int'(div_word), int'(plan.div));
      chk(req, "final ref_sel", int'(ref_sel), int'(plan.rsel));
      chk(req, "final control", int'(ctl_now()), int'(plan.ctl));
      chk(req, "final sw_en", int'(sw_en), int'(plan.sw));
   endtask

   initial begin
      plan = '{due: 0, div: '0, rsel: '0, ctl: '0, sw: '0, sdal: 1'b0};
      cur = plan;
      m_pos = 0; m_bad = 0; m_pend = 0; m_addr = 0;
      sh_div = '0; sh_ref = '0;
      wt(6);
      rst_n = 1'b1;
      wt(4);

      // R1: reset state
      chk("R1", "reset div_word", int'(div_word), 0);
      chk("R1", "reset control", int'(ctl_now()), 0);
      chk("R1", "reset sw_en", int'(sw_en), 0);
      chk("R1", "reset sda_low", int'(sda_low), 0);

      // R4, R5, R7, R8: full divider + control transfer, address pins 10
      cur_req = "R4";
      bus_start();
      send_byte(8'hC4, 1);
      send_byte(8'h5A, 0);
      send_byte(8'h33, 0);
      send_byte(8'h41, 0);
      send_byte(8'hA6, 0);
      send_byte(8'hAD, 0);
      bus_stop();
      final_chk("R4");
      chk("R5", "div after stop", int'(div_word), int'({7'h5A, 7'h33, 1'b1}));
      chk("R5", "ref after stop", int'(ref_sel), 2);
      chk("R7", "cp_code", int'(cp_code), 1);
      chk("R8", "switches", int'(sw_en), 6'h2D);

      // R2: wrong address, then read direction bit
      cur_req = "R2";
      bus_start();
      send_byte(8'hC6, 1);
      send_byte(8'h01, 0);
      send_byte(8'hFF, 0);
      bus_stop();
      bus_start();
      send_byte(8'hC5, 1);
      send_byte(8'h80, 0);
      bus_stop();
      final_chk("R2");

      // R6: early end after the first divider byte
      cur_req = "R6";
      bus_start();
      send_byte(8'hC4, 1);
      send_byte(8'h11, 0);
      bus_stop();
      final_chk("R6");
      chk("R6", "upper bits only", int'(div_word), int'({7'h11, 7'h33, 1'b1}));

      // R7: control-only transfers sweeping the charge-pump code
      cur_req = "R7";
      for (int c = 0; c < 4; c++) begin
         bus_start();
         send_byte(8'hC4, 1);
         send_byte({1'b1, 1'b1, 1'b0, 1'b1, 2'(c), 1'b0, 1'b1}, 0);
         bus_stop();
         settle();
         chk("R7", "cp_code sweep", int'(cp_code), c);
      end
      final_chk("R7");

      // R8: control pair, switch enables
      cur_req = "R8";
      bus_start();
      send_byte(8'hC4, 1);
      send_byte(8'h82, 0);
      send_byte(8'hB5, 0);
      bus_stop();
      final_chk("R8");

      // R9: divider byte directly followed by a control byte
      cur_req = "R9";
      bus_start();
      send_byte(8'hC4, 1);
      send_byte(8'h7F, 0);
      send_byte(8'hFF, 0);
      bus_stop();
      final_chk("R9");

      // R9: divider byte where the first control byte is expected
      bus_start();
      send_byte(8'hC4, 1);
      send_byte(8'h22, 0);
      send_byte(8'h44, 0);
      send_byte(8'h20, 0);
      send_byte(8'h05, 0);
      bus_stop();
      final_chk("R9");

      // R9: byte after the second control byte
      bus_start();
      send_byte(8'hC4, 1);
      send_byte(8'h90, 0);
      send_byte(8'h8A, 0);
      send_byte(8'hFF, 0);
      bus_stop();
      final_chk("R9");

      // R2, R3: other address pins, full divider run
      cur_req = "R3";
      a_sel = 2'b01;
      wt(4);
      bus_start();
      send_byte(8'hC2, 1);
      send_byte(8'h03, 0);
      send_byte(8'h7E, 0);
      send_byte(8'h60, 0);
      bus_stop();
      final_chk("R3");
      chk("R2", "addr pins 01 div", int'(div_word), int'({7'h03, 7'h7E, 1'b0}));

      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (WD) @(posedge clk);
      if (!done) begin
         done = 1;
         nchk++;
         nerr++;
         $display("FAIL watchdog run did not complete actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end
endmodule